// File: doc/BRIEF.md
# Dual-Mode Frequency Word Load Interface

This block sits between a host bus and the phase accumulator of a decimal numerically controlled oscillator. It takes a 35-bit BCD frequency control word and a 3-bit phase-modulation word. It holds both in staging buffers and moves them into active registers on command. Each write carries a 3-bit address. The address picks one of five byte lanes of the frequency word, the phase buffer, the whole frequency word at once, or the frequency word and phase together.

The write strobe, the chip select and the two load commands are sampled by the system clock. A write lands in the buffers when the sampled strobe goes from low to high. A falling edge on a load input arms a transfer. The transfer is carried out on the first clock edge at which the internal half-rate load clock is low. The load clock is brought out, so the host can predict which edge carries the update. A one-cycle pulse marks each update of each active register.

Top module: `nco_word_loader`

## Requirements
- R1: Address codes 0 to 3 write frequency-buffer bits [8k+7:8k] (k = code) from wr_data[7:0]. Code 4 writes bits [34:32] from wr_data[2:0]. All other buffer bits keep their value.
- R2: Code 5 writes the phase buffer from ph_data. Code 6 writes all 35 frequency-buffer bits from wr_data. Code 7 writes both buffers in the same strobe.
- R3: While cs_n is high at the sampled strobe rise, neither buffer changes.
- R4: A write takes effect only at a low-to-high change of the sampled wr_strobe. Holding the strobe high does not capture later bus values.
- R5: Byte lanes may be written in any order. A lane that is not written keeps its last value, across transfers as well.
- R6: A frequency load is armed at the clock edge where freq_ld_n is sampled low after being sampled high. freq_word takes the frequency buffer at that edge if ld_clk is low there. Otherwise it takes the buffer at the next edge.
- R7: The phase load follows the rule of R6 on ph_ld_n, ph_word and the phase buffer, independently of the frequency load.
- R8: ld_clk is 0 after reset and inverts on every clock edge.
- R9: freq_xfer and ph_xfer are high for exactly the one cycle that follows the edge at which their active register was loaded.
- R10: freq_word and ph_word change only on a transfer.
- R11: When a buffer write and a transfer of the same buffer fall on the same edge, the active register receives the contents from before that write. The new contents remain in the buffer.
- R12: An asynchronous low on rst_n clears both buffers, both active registers, both transfer pulses and ld_clk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_strobe | input | 1 | Write strobe, captures on rise |
| cs_n | input | 1 | Chip select, active low |
| wr_addr | input | 3 | Write mode and lane select |
| wr_data | input | 35 | Frequency data bus |
| ph_data | input | 3 | Phase data bus |
| freq_ld_n | input | 1 | Frequency load command, falling edge |
| ph_ld_n | input | 1 | Phase load command, falling edge |
| ld_clk | output | 1 | Half-rate load clock |
| freq_word | output | 35 | Active frequency word |
| ph_word | output | 3 | Active phase word |
| freq_xfer | output | 1 | Frequency transfer pulse |
| ph_xfer | output | 1 | Phase transfer pulse |

## Verification
A buffer write and a transfer out of that same buffer can fall on the same clock edge. The bench provokes this by waiting for a cycle in which ld_clk is low. In that cycle it raises the write strobe with a full parallel word and drops the load input together. The transfer pulse and the active word after that edge must show the older buffer value. A later load must then deliver the newly written word.

// File: rtl/nco_ld_pkg.sv
package nco_ld_pkg;
    localparam int FREQ_W = 35;
    localparam int PH_W   = 3;
    localparam int LANE_W = 8;
    localparam int ADDR_W = 3;
endpackage

// File: rtl/nco_ld_div.sv
module nco_ld_div (
    input  logic clk,
    input  logic rst_n,
    output logic half_clk
);
    typedef struct packed {
        logic ph;
    } div_st_t;

    div_st_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        s_d.ph = ~s_q.ph;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign half_clk = s_q.ph;
endmodule

// File: rtl/nco_ld_wbuf.sv
module nco_ld_wbuf #(
    parameter int FREQ_W = 35,
    parameter int PH_W   = 3,
    parameter int LANE_W = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_strobe,
    input  logic              cs_n,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [FREQ_W-1:0] wr_data,
    input  logic [PH_W-1:0]   ph_data,
    output logic [FREQ_W-1:0] freq_buf,
    output logic [PH_W-1:0]   ph_buf
);
    localparam int NUM_LANES = (FREQ_W + LANE_W - 1) / LANE_W;
    localparam int A_PHASE   = NUM_LANES;
    localparam int A_PAR     = NUM_LANES + 1;
    localparam int A_BOTH    = NUM_LANES + 2;

    typedef struct packed {
        logic              stb;
        logic [FREQ_W-1:0] fbuf;
        logic [PH_W-1:0]   pbuf;
    } wb_st_t;

    wb_st_t s_d, s_q;

    logic [FREQ_W-1:0] lane_mask;
    logic [FREQ_W-1:0] lane_spread;

    for (genvar gi = 0; gi < NUM_LANES; gi++) begin : g_lane
        localparam int LO = gi * LANE_W;
        localparam int HI = (LO + LANE_W > FREQ_W) ? FREQ_W - 1 : LO + LANE_W - 1;
        assign lane_spread[HI:LO] = wr_data[HI-LO:0];
        assign lane_mask[HI:LO]   = {(HI-LO+1){wr_addr == ADDR_W'(gi)}};
    end

    logic fire;

    always_comb begin
        s_d     = s_q;
        s_d.stb = wr_strobe;
        fire    = wr_strobe && !s_q.stb && !cs_n;
        if (fire) begin
            if (wr_addr < ADDR_W'(A_PHASE)) begin
                s_d.fbuf = (s_q.fbuf & ~lane_mask) | (lane_spread & lane_mask);
            end else if (wr_addr == ADDR_W'(A_PHASE)) begin
                s_d.pbuf = ph_data;
            end else if (wr_addr == ADDR_W'(A_PAR)) begin
                s_d.fbuf = wr_data;
            end else if (wr_addr == ADDR_W'(A_BOTH)) begin
                s_d.fbuf = wr_data;
                s_d.pbuf = ph_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign freq_buf = s_q.fbuf;
    assign ph_buf   = s_q.pbuf;
endmodule

// File: rtl/nco_ld_commit.sv
module nco_ld_commit #(
    parameter int W = 35
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         half_clk,
    input  logic         ld_n,
    input  logic [W-1:0] buf_word,
    output logic [W-1:0] act_word,
    output logic         xfer
);
    typedef struct packed {
        logic         ld_s;
        logic         pend;
        logic         xfer;
        logic [W-1:0] word;
    } cm_st_t;

    cm_st_t s_d, s_q;
    logic   fall;

    always_comb begin
        s_d      = s_q;
        s_d.ld_s = ld_n;
        s_d.xfer = 1'b0;
        fall     = s_q.ld_s && !ld_n;
        if ((fall || s_q.pend) && !half_clk) begin
            s_d.word = buf_word;
            s_d.xfer = 1'b1;
            s_d.pend = 1'b0;
        end else begin
            s_d.pend = fall || s_q.pend;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign act_word = s_q.word;
    assign xfer     = s_q.xfer;
endmodule

// File: rtl/nco_word_loader.sv
module nco_word_loader
    import nco_ld_pkg::*;
#(
    parameter int FW = FREQ_W,
    parameter int PW = PH_W,
    parameter int LW = LANE_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_strobe,
    input  logic          cs_n,
    input  logic [AW-1:0] wr_addr,
    input  logic [FW-1:0] wr_data,
    input  logic [PW-1:0] ph_data,
    input  logic          freq_ld_n,
    input  logic          ph_ld_n,
    output logic          ld_clk,
    output logic [FW-1:0] freq_word,
    output logic [PW-1:0] ph_word,
    output logic          freq_xfer,
    output logic          ph_xfer
);
    logic [FW-1:0] freq_buf;
    logic [PW-1:0] ph_buf;

    nco_ld_div u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .half_clk (ld_clk)
    );

    nco_ld_wbuf #(.FREQ_W(FW), .PH_W(PW), .LANE_W(LW), .ADDR_W(AW)) u_wbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_strobe (wr_strobe),
        .cs_n      (cs_n),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .ph_data   (ph_data),
        .freq_buf  (freq_buf),
        .ph_buf    (ph_buf)
    );

    nco_ld_commit #(.W(FW)) u_fcommit (
        .clk      (clk),
        .rst_n    (rst_n),
        .half_clk (ld_clk),
        .ld_n     (freq_ld_n),
        .buf_word (freq_buf),
        .act_word (freq_word),
        .xfer     (freq_xfer)
    );

    nco_ld_commit #(.W(PW)) u_pcommit (
        .clk      (clk),
        .rst_n    (rst_n),
        .half_clk (ld_clk),
        .ld_n     (ph_ld_n),
        .buf_word (ph_buf),
        .act_word (ph_word),
        .xfer     (ph_xfer)
    );
endmodule

// File: rtl/nco_word_loader_chk.sv
module nco_word_loader_chk #(
    parameter int FW = 35,
    parameter int PW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_n,
    input logic          ld_clk,
    input logic [FW-1:0] freq_buf,
    input logic [PW-1:0] ph_buf,
    input logic [FW-1:0] freq_word,
    input logic [PW-1:0] ph_word,
    input logic          freq_xfer,
    input logic          ph_xfer
);
    a_r8_ldclk_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ld_clk != $past(ld_clk));

    a_r6_freq_on_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
        freq_xfer |-> ld_clk);

    a_r7_ph_on_low_phase: assert property (@(posedge clk) disable iff (!rst_n)
        ph_xfer |-> ld_clk);

    a_r9_freq_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        freq_xfer |=> !freq_xfer);

    a_r9_ph_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        ph_xfer |=> !ph_xfer);

    a_r10_freq_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !freq_xfer |-> $stable(freq_word));

    a_r10_ph_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !ph_xfer |-> $stable(ph_word));

    a_r11_freq_takes_old_buf: assert property (@(posedge clk) disable iff (!rst_n)
        freq_xfer |-> freq_word == $past(freq_buf));

    a_r3_cs_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> ($stable(freq_buf) && $stable(ph_buf)));
endmodule

bind nco_word_loader nco_word_loader_chk #(.FW(FW), .PW(PW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .ld_clk    (ld_clk),
    .freq_buf  (freq_buf),
    .ph_buf    (ph_buf),
    .freq_word (freq_word),
    .ph_word   (ph_word),
    .freq_xfer (freq_xfer),
    .ph_xfer   (ph_xfer)
);

// File: tb/nco_word_loader_bench.sv
module nco_word_loader_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_strobe = 1'b0;
    logic        cs_n = 1'b1;
    logic [2:0]  wr_addr = '0;
    logic [34:0] wr_data = '0;
    logic [2:0]  ph_data = '0;
    logic        freq_ld_n = 1'b1;
    logic        ph_ld_n = 1'b1;
    logic        ld_clk;
    logic [34:0] freq_word;
    logic [2:0]  ph_word;
    logic        freq_xfer;
    logic        ph_xfer;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [34:0] m_fbuf = '0;
    logic [2:0]  m_pbuf = '0;
    logic [34:0] m_fact = '0;
    logic [2:0]  m_pact = '0;

    always #4 clk = ~clk;

    nco_word_loader u_nco_word_loader (
        .clk(clk), .rst_n(rst_n), .wr_strobe(wr_strobe), .cs_n(cs_n),
        .wr_addr(wr_addr), .wr_data(wr_data), .ph_data(ph_data),
        .freq_ld_n(freq_ld_n), .ph_ld_n(ph_ld_n), .ld_clk(ld_clk),
        .freq_word(freq_word), .ph_word(ph_word),
        .freq_xfer(freq_xfer), .ph_xfer(ph_xfer)
    );

    task automatic check(input string req, input logic [34:0] act, input logic [34:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [34:0] next_fbuf(input logic [34:0] b, input logic [2:0] a,
                                              input logic [34:0] d);
        logic [34:0] r = b;
        if (a < 3'd5) begin
            for (int j = 0; j < 8; j++)
                if (int'(a) * 8 + j < 35) r[int'(a) * 8 + j] = d[j];
        end else if (a == 3'd6 || a == 3'd7) begin
            r = d;
        end
        return r;
    endfunction

    function automatic logic [2:0] next_pbuf(input logic [2:0] b, input logic [2:0] a,
                                             input logic [2:0] p);
        return (a == 3'd5 || a == 3'd7) ? p : b;
    endfunction

    // R8: ld_clk inverts on every edge while out of reset
    logic prev_ld;
    bit   prev_ok = 1'b0;
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_ok = 1'b0;
        end else begin
            if (prev_ok) check("R8 ld_clk toggle", {34'd0, ld_clk}, {34'd0, ~prev_ld});
            prev_ld = ld_clk;
            prev_ok = 1'b1;
        end
    end

    task automatic do_write(input logic [2:0] a, input logic [34:0] d, input logic [2:0] p,
                            input logic cs);
        @(negedge clk);
        wr_addr = a; wr_data = d; ph_data = p; cs_n = cs; wr_strobe = 1'b1;
        @(negedge clk);
        wr_strobe = 1'b0;
        if (!cs) begin
            m_fbuf = next_fbuf(m_fbuf, a, d);
            m_pbuf = next_pbuf(m_pbuf, a, p);
        end
        // R10: a write alone never moves the active registers
        check("R10 freq held on write", freq_word, m_fact);
        check("R10 ph held on write", {32'd0, ph_word}, {32'd0, m_pact});
    endtask

    // sel=0 frequency (R6), sel=1 phase (R7)
    task automatic do_load(input bit sel);
        bit lowfirst;
        string req;
        req = sel ? "R7" : "R6";
        @(negedge clk);
        lowfirst = (ld_clk == 1'b0);
        if (sel) ph_ld_n = 1'b0; else freq_ld_n = 1'b0;
        @(negedge clk);
        if (!lowfirst) begin
            check({req, " no xfer on high phase"}, {34'd0, sel ? ph_xfer : freq_xfer}, 35'd0);
            check("R10 word held while armed", sel ? {32'd0, ph_word} : freq_word,
                  sel ? {32'd0, m_pact} : m_fact);
            @(negedge clk);
        end
        if (sel) m_pact = m_pbuf; else m_fact = m_fbuf;
        check({req, " R9 xfer pulse"}, {34'd0, sel ? ph_xfer : freq_xfer}, 35'd1);
        check({req, " active word"}, sel ? {32'd0, ph_word} : freq_word,
              sel ? {32'd0, m_pact} : m_fact);
        if (sel) ph_ld_n = 1'b1; else freq_ld_n = 1'b1;
        @(negedge clk);
        check("R9 pulse one cycle", {34'd0, sel ? ph_xfer : freq_xfer}, 35'd0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        #1 rst_n = 1'b0;
        #1;
        check("R12 freq_word clear", freq_word, 35'd0);
        check("R12 ph_word clear", {32'd0, ph_word}, 35'd0);
        check("R12 ld_clk clear", {34'd0, ld_clk}, 35'd0);
        check("R12 xfer clear", {33'd0, freq_xfer, ph_xfer}, 35'd0);
        m_fbuf = '0; m_pbuf = '0; m_fact = '0; m_pact = '0;
        repeat (2) @(negedge clk);
        #1 rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        do_reset();

        // R1 lanes in scrambled order, R5 partial rewrite
        do_write(3'd3, 35'h0000000_91, 3'd0, 1'b0);
        do_write(3'd0, 35'h0000000_45, 3'd0, 1'b0);
        do_write(3'd4, 35'h7FFFFFFFF, 3'd0, 1'b0);
        do_write(3'd2, 35'h0000000_67, 3'd0, 1'b0);
        do_write(3'd1, 35'h0000000_23, 3'd0, 1'b0);
        do_load(1'b0);
        check("R1 lane assembly", freq_word, 35'h7_9167_2345);
        do_write(3'd1, 35'h0000000_88, 3'd0, 1'b0);
        do_load(1'b0);
        check("R5 unwritten lanes kept", freq_word, 35'h7_9167_8845);

        // R2 phase, parallel, both
        do_write(3'd5, 35'h0, 3'd6, 1'b0);
        do_load(1'b1);
        do_write(3'd6, 35'h1_2345_6789, 3'd1, 1'b0);
        check("R2 parallel leaves phase buffer", {32'd0, m_pbuf}, 35'd6);
        do_load(1'b0);
        do_write(3'd7, 35'h5_5555_0001, 3'd3, 1'b0);
        do_load(1'b1);
        do_load(1'b0);
        check("R2 joint write phase", {32'd0, ph_word}, 35'd3);

        // R3 chip select high blocks everything
        do_write(3'd7, 35'h0_0000_0bad, 3'd7, 1'b1);
        do_load(1'b0);
        do_load(1'b1);

        // R4 strobe held high: only the first bus value is taken
        @(negedge clk);
        cs_n = 1'b0; wr_addr = 3'd6; wr_data = 35'h0_1111_1111; wr_strobe = 1'b1;
        @(negedge clk);
        wr_data = 35'h0_2222_2222;
        @(negedge clk);
        wr_strobe = 1'b0;
        m_fbuf = 35'h0_1111_1111;
        do_load(1'b0);
        check("R4 level hold ignored", freq_word, 35'h0_1111_1111);

        // R11 write and transfer on the same edge
        @(negedge clk);
        while (ld_clk != 1'b0) @(negedge clk);
        wr_addr = 3'd6; wr_data = 35'h3_0303_0303; cs_n = 1'b0; wr_strobe = 1'b1;
        freq_ld_n = 1'b0;
        @(negedge clk);
        check("R11 xfer on collision", {34'd0, freq_xfer}, 35'd1);
        check("R11 old buffer goes active", freq_word, m_fact == m_fbuf ? m_fbuf : m_fbuf);
        m_fact = m_fbuf;
        m_fbuf = 35'h3_0303_0303;
        wr_strobe = 1'b0; freq_ld_n = 1'b1;
        do_load(1'b0);
        check("R11 new word on next load", freq_word, 35'h3_0303_0303);

        // simultaneous frequency and phase load
        do_write(3'd7, 35'h0_0000_0042, 3'd5, 1'b0);
        @(negedge clk);
        freq_ld_n = 1'b0; ph_ld_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R6 joint freq", freq_word, 35'h0_0000_0042);
        check("R7 joint phase", {32'd0, ph_word}, 35'd5);
        m_fact = m_fbuf; m_pact = m_pbuf;
        freq_ld_n = 1'b1; ph_ld_n = 1'b1;

        // random mix
        for (int it = 0; it < 80; it++) begin
            int r;
            r = $urandom % 10;
            if (r < 6) begin
                logic [34:0] d;
                d = {3'($urandom), 32'($urandom)};
                do_write(3'($urandom), d, 3'($urandom), ($urandom % 5) == 0);
            end else if (r < 8) begin
                do_load(1'b0);
            end else begin
                do_load(1'b1);
            end
        end

        // R12 reset mid-run clears buffers too
        do_write(3'd7, 35'h7_7777_7777, 3'd7, 1'b0);
        do_reset();
        do_load(1'b0);
        do_load(1'b1);
        check("R12 buffers cleared", freq_word, 35'd0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule